// File: doc/BRIEF.md
# USB 1.1 Host Controller Command and Status Registers

This block is the software-visible control core of a full/low-speed USB host controller. A 16-bit register port reads and writes five locations. These are a command word, a write-one-to-clear status word, an interrupt-enable word, the current frame index and the page base of the frame list.

The transaction engine reports finished work to the block as single-cycle pulses: completion, error and short packet. The block merges these into one level interrupt. It also turns the run/stop command into a halted indication that only takes effect on a frame boundary.

While the controller runs, a 1 ms frame tick moves a 10-bit frame index forward. The block combines that index with the frame-list page to give the address of the current frame-list entry. A transfer-permit output tells the engine whether it may start transactions. That output is dropped while the controller is stopped, halted or in global suspend.

Top module: `hc_csr_top`

## Requirements
- R1: After reset, offset 0x0 (command) reads 0x0000, offset 0x2 (status) reads 0x0020, and offsets 0x4, 0x8 and 0xA read 0x0000. Any other offset always reads 0x0000. `hc_halted` is 1, and `irq`, `xfer_ok`, `frame_idx` and `fl_entry_addr` are 0.
- R2: The command word stores bits 0 (run), 2 (global reset), 3 (global suspend), 4 (force resume), 6 (configure flag) and 7 (64-byte max packet) exactly as written. Bits 5 and 8-15 read 0.
- R3: Writing command bit 1 makes that bit read 1 in the following cycle only. One cycle after that, every register is back at its R1 value, with run 0 and halted 1.
- R4: The configure flag (command bit 6) changes no output other than its own readback.
- R5: Setting run clears halted (status bit 5) one clock after run is stored. Clearing run leaves halted at 0 until the next frame tick, which sets it.
- R6: The frame index (offset 0x8, bits 9:0) advances by one on each frame tick only while run is 1 and halted is 0, and wraps from 1023 to 0. A write to offset 0x8 loads the index and wins over a tick in the same cycle.
- R7: Offset 0xA keeps only bits 15:12; bits 11:0 read 0. `fl_entry_addr` equals {base bits 15:12, frame index, 2'b00}.
- R8: In the status word, writing 1 to bit 0, 1 or 5 clears that bit, and writing 0 leaves it. An event arriving in the same cycle as the clear leaves its bit set. A frame tick that stops the controller sets halted even if halted was just cleared by software.
- R9: A completion pulse or a short-packet pulse sets status bit 0, and an error pulse sets status bit 1, whatever the enables hold.
- R10: Interrupt enable bit 2 gates completion causes and bit 3 gates short-packet causes. The other enable bits read 0. `irq` is 1 exactly when an enabled cause is recorded or status bit 1 is set.
- R11: `xfer_ok` is 1 only when run is 1, halted is 0 and global suspend (command bit 3) is 0.
- R12: `max_pkt_64` follows command bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_done | input | 1 | Transfer completed pulse |
| evt_err | input | 1 | Transfer error pulse |
| evt_short | input | 1 | Short packet pulse |
| frame_tick | input | 1 | 1 ms frame boundary pulse |
| irq | output | 1 | Merged interrupt level |
| hc_halted | output | 1 | Controller halted |
| xfer_ok | output | 1 | Transactions may be started |
| max_pkt_64 | output | 1 | 64-byte maximum packet selected |
| frame_idx | output | 10 | Current frame index |
| fl_entry_addr | output | 16 | Address of the current frame-list entry |

## Verification
The bench builds the block with its defaults: a 16-bit data path and a 10-bit frame index, which leaves a 4-bit page field for the frame-list base. With this index width, the wrap from 1023 to 0 is one loaded value and one tick away. The 4+10+2 address split can be checked against a single hand-computed address. The same widths let the bench sweep every command and enable bit with one write of all ones.

// File: rtl/hc_csr_pkg.sv
package hc_csr_pkg;

    // register offsets on the byte-addressed port
    localparam int OFS_CMD   = 0;
    localparam int OFS_STS   = 2;
    localparam int OFS_IEN   = 4;
    localparam int OFS_FNUM  = 8;
    localparam int OFS_FBASE = 10;

    // command word bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_HCRST = 1;
    localparam int CB_GRST  = 2;
    localparam int CB_SUSP  = 3;
    localparam int CB_RSM   = 4;
    localparam int CB_CFG   = 6;
    localparam int CB_MPS   = 7;

    // status word bit positions
    localparam int SB_DONE = 0;
    localparam int SB_ERR  = 1;
    localparam int SB_HALT = 5;

    // interrupt enable bit positions
    localparam int IB_DONE  = 2;
    localparam int IB_SHORT = 3;

    typedef struct packed {
        logic hcrst;
        logic mps;
        logic cfg;
        logic rsm;
        logic susp;
        logic grst;
        logic run;
    } cmd_bits_t;

    typedef struct packed {
        logic done_c;
        logic short_c;
        logic err_c;
        logic en_done;
        logic en_short;
    } irq_state_t;

endpackage

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg
    import hc_csr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output cmd_bits_t         cmd_o,
    output logic [DATA_W-1:0] rdata_o
);

    cmd_bits_t cmd_d, cmd_q;

    wire unused_wbits = ^{wdata[DATA_W-1:8], wdata[5]};

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.hcrst = 1'b0;
        if (wr_en) begin
            if (wdata[CB_HCRST]) begin
                cmd_d       = '0;
                cmd_d.hcrst = 1'b1;
            end else begin
                cmd_d.run  = wdata[CB_RUN];
                cmd_d.grst = wdata[CB_GRST];
                cmd_d.susp = wdata[CB_SUSP];
                cmd_d.rsm  = wdata[CB_RSM];
                cmd_d.cfg  = wdata[CB_CFG];
                cmd_d.mps  = wdata[CB_MPS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[CB_RUN]   = cmd_q.run;
        rdata_o[CB_HCRST] = cmd_q.hcrst;
        rdata_o[CB_GRST]  = cmd_q.grst;
        rdata_o[CB_SUSP]  = cmd_q.susp;
        rdata_o[CB_RSM]   = cmd_q.rsm;
        rdata_o[CB_CFG]   = cmd_q.cfg;
        rdata_o[CB_MPS]   = cmd_q.mps;
    end

    assign cmd_o = cmd_q;

    // R3: the reset request lasts a single cycle unless written again
    a_r3_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q.hcrst && !(wr_en && wdata[CB_HCRST]) |=> !cmd_q.hcrst);

    // R2: run follows a plain command write
    a_r2_run_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wdata[CB_HCRST] |=> cmd_q.run == $past(wdata[CB_RUN]));

endmodule

// File: rtl/hc_run_frame.sv
module hc_run_frame #(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic               tick,
    input  logic               halt_w1c,
    input  logic               fnum_wr,
    input  logic [FRAME_W-1:0] fnum_wdata,
    output logic               halted_o,
    output logic [FRAME_W-1:0] frame_o
);

    typedef struct packed {
        logic               halted;
        logic [FRAME_W-1:0] frame;
    } rf_state_t;

    localparam rf_state_t RF_RST = '{halted: 1'b1, frame: '0};

    rf_state_t rf_d, rf_q;
    logic      advance;

    assign advance = tick && run && !rf_q.halted;

    always_comb begin
        rf_d = rf_q;
        if (advance) rf_d.frame = rf_q.frame + 1'b1;
        if (fnum_wr) rf_d.frame = fnum_wdata;
        if (run)           rf_d.halted = 1'b0;
        else if (tick)     rf_d.halted = 1'b1;
        else if (halt_w1c) rf_d.halted = 1'b0;
        if (clr) rf_d = RF_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= RF_RST;
        else        rf_q <= rf_d;
    end

    assign halted_o = rf_q.halted;
    assign frame_o  = rf_q.frame;

    // R5: a running controller is never halted one clock later
    a_r5_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
        run && !clr |=> !halted_o);

    // R5: after a stop, halted waits for a frame boundary
    a_r5_stop_waits: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !tick && !halt_w1c && !clr |=> halted_o == $past(halted_o));

    // R6: one step per qualified tick, wrapping naturally
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick && run && !halted_o && !fnum_wr && !clr
        |=> frame_o == FRAME_W'($past(frame_o) + 1'b1));

    // R6: no tick, no write, no reset leaves the index alone
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !fnum_wr && !clr |=> $stable(frame_o));

endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status
    import hc_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic evt_done,
    input  logic evt_err,
    input  logic evt_short,
    input  logic w1c_done,
    input  logic w1c_err,
    input  logic ien_wr,
    input  logic ien_done_wr,
    input  logic ien_short_wr,
    output logic irq_o,
    output logic done_o,
    output logic err_o,
    output logic en_done_o,
    output logic en_short_o
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (w1c_done) begin
            st_d.done_c  = 1'b0;
            st_d.short_c = 1'b0;
        end
        if (w1c_err)   st_d.err_c   = 1'b0;
        if (evt_done)  st_d.done_c  = 1'b1;
        if (evt_short) st_d.short_c = 1'b1;
        if (evt_err)   st_d.err_c   = 1'b1;
        if (ien_wr) begin
            st_d.en_done  = ien_done_wr;
            st_d.en_short = ien_short_wr;
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = (st_q.done_c && st_q.en_done) ||
                   (st_q.short_c && st_q.en_short) ||
                   st_q.err_c;
    assign done_o     = st_q.done_c || st_q.short_c;
    assign err_o      = st_q.err_c;
    assign en_done_o  = st_q.en_done;
    assign en_short_o = st_q.en_short;

    // R8: an error event beats a simultaneous clear
    a_r8_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err && !clr |=> err_o);

    // R8: a clear without a new event empties the error cause
    a_r8_w1c_err: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_err && !evt_err && !clr |=> !err_o);

    // R9: completion is recorded regardless of enables
    a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done || evt_short) && !clr |=> done_o);

    // R3: reset request silences the interrupt
    a_r3_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !irq_o);

endmodule

// File: rtl/hc_csr_top.sv
module hc_csr_top
    import hc_csr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               evt_done,
    input  logic               evt_err,
    input  logic               evt_short,
    input  logic               frame_tick,
    output logic               irq,
    output logic               hc_halted,
    output logic               xfer_ok,
    output logic               max_pkt_64,
    output logic [FRAME_W-1:0] frame_idx,
    output logic [DATA_W-1:0]  fl_entry_addr
);

    localparam int FL_LSB = FRAME_W + 2;
    localparam int BASE_W = DATA_W - FL_LSB;

    cmd_bits_t         cmd;
    logic [DATA_W-1:0] cmd_rdata;
    logic              wr_cmd, wr_sts, wr_ien, wr_fnum, wr_fbase;
    logic              sts_done, sts_err, en_done, en_short;
    logic [BASE_W-1:0] fb_d, fb_q;

    wire unused_cmd = ^{cmd.grst, cmd.rsm, cmd.cfg};

    assign wr_cmd   = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
    assign wr_sts   = reg_wr && (reg_addr == ADDR_W'(OFS_STS));
    assign wr_ien   = reg_wr && (reg_addr == ADDR_W'(OFS_IEN));
    assign wr_fnum  = reg_wr && (reg_addr == ADDR_W'(OFS_FNUM));
    assign wr_fbase = reg_wr && (reg_addr == ADDR_W'(OFS_FBASE));

    hc_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cmd),
        .wdata   (reg_wdata),
        .cmd_o   (cmd),
        .rdata_o (cmd_rdata)
    );

    hc_run_frame #(.FRAME_W(FRAME_W)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cmd.hcrst),
        .run        (cmd.run),
        .tick       (frame_tick),
        .halt_w1c   (wr_sts && reg_wdata[SB_HALT]),
        .fnum_wr    (wr_fnum),
        .fnum_wdata (reg_wdata[FRAME_W-1:0]),
        .halted_o   (hc_halted),
        .frame_o    (frame_idx)
    );

    hc_irq_status u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (cmd.hcrst),
        .evt_done     (evt_done),
        .evt_err      (evt_err),
        .evt_short    (evt_short),
        .w1c_done     (wr_sts && reg_wdata[SB_DONE]),
        .w1c_err      (wr_sts && reg_wdata[SB_ERR]),
        .ien_wr       (wr_ien),
        .ien_done_wr  (reg_wdata[IB_DONE]),
        .ien_short_wr (reg_wdata[IB_SHORT]),
        .irq_o        (irq),
        .done_o       (sts_done),
        .err_o        (sts_err),
        .en_done_o    (en_done),
        .en_short_o   (en_short)
    );

    // frame-list page register
    always_comb begin
        fb_d = fb_q;
        if (wr_fbase)  fb_d = reg_wdata[DATA_W-1:FL_LSB];
        if (cmd.hcrst) fb_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assign fl_entry_addr = {fb_q, frame_idx, 2'b00};
    assign xfer_ok       = cmd.run && !hc_halted && !cmd.susp;
    assign max_pkt_64    = cmd.mps;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_CMD):   reg_rdata = cmd_rdata;
            ADDR_W'(OFS_STS): begin
                reg_rdata[SB_DONE] = sts_done;
                reg_rdata[SB_ERR]  = sts_err;
                reg_rdata[SB_HALT] = hc_halted;
            end
            ADDR_W'(OFS_IEN): begin
                reg_rdata[IB_DONE]  = en_done;
                reg_rdata[IB_SHORT] = en_short;
            end
            ADDR_W'(OFS_FNUM):  reg_rdata[FRAME_W-1:0] = frame_idx;
            ADDR_W'(OFS_FBASE): reg_rdata[DATA_W-1:FL_LSB] = fb_q;
            default:            reg_rdata = '0;
        endcase
    end

    // R6: a halted controller keeps its frame index
    a_r6_frozen_halted: assert property (@(posedge clk) disable iff (!rst_n)
        hc_halted && !wr_fnum && !cmd.hcrst |=> $stable(frame_idx));

    // R11: permit is withdrawn after a stop reaches the frame boundary
    a_r11_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.run && frame_tick && !cmd.hcrst |=> !xfer_ok);

endmodule

// File: tb/hc_csr_top_tb_top.sv
module hc_csr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        evt_done = 1'b0, evt_err = 1'b0, evt_short = 1'b0;
    logic        frame_tick = 1'b0;
    logic        irq, hc_halted, xfer_ok, max_pkt_64;
    logic [9:0]  frame_idx;
    logic [15:0] fl_entry_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5ns clk = ~clk;

    hc_csr_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .evt_done      (evt_done),
        .evt_err       (evt_err),
        .evt_short     (evt_short),
        .frame_tick    (frame_tick),
        .irq           (irq),
        .hc_halted     (hc_halted),
        .xfer_ok       (xfer_ok),
        .max_pkt_64    (max_pkt_64),
        .frame_idx     (frame_idx),
        .fl_entry_addr (fl_entry_addr)
    );

    typedef struct packed {
        logic [3:0]  waddr;
        logic [15:0] wdata;
        logic [3:0]  raddr;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 16'hFFFD, 4'h0, 16'h00DD, 8'd2},
        '{4'h2, 16'hFFFF, 4'h2, 16'h0000, 8'd5},
        '{4'h4, 16'hFFFF, 4'h4, 16'h000C, 8'd10},
        '{4'h8, 16'hFFFF, 4'h8, 16'h03FF, 8'd6},
        '{4'hA, 16'hABCD, 4'hA, 16'hA000, 8'd7},
        '{4'h6, 16'hFFFF, 4'h6, 16'h0000, 8'd1},
        '{4'h0, 16'h0040, 4'h0, 16'h0040, 8'd2},
        '{4'h8, 16'h0000, 4'h2, 16'h0000, 8'd5},
        '{4'h0, 16'h0000, 4'h0, 16'h0000, 8'd2}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_wr = 1'b0;
        evt_done = 1'b0; evt_err = 1'b0; evt_short = 1'b0; frame_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1ns;
        d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic evt(input logic d, input logic e, input logic s);
        @(negedge clk);
        evt_done = d; evt_err = e; evt_short = s;
        @(negedge clk);
        evt_done = 1'b0; evt_err = 1'b0; evt_short = 1'b0;
    endtask

    task automatic chk_defaults(input string tag);
        logic [15:0] v;
        rd(4'h0, v); chk({tag, " cmd"}, v, 16'h0000);
        rd(4'h2, v); chk({tag, " sts"}, v, 16'h0020);
        rd(4'h4, v); chk({tag, " ien"}, v, 16'h0000);
        rd(4'h8, v); chk({tag, " fnum"}, v, 16'h0000);
        rd(4'hA, v); chk({tag, " fbase"}, v, 16'h0000);
        chk({tag, " halted"}, {15'd0, hc_halted}, 16'd1);
        chk({tag, " irq"}, {15'd0, irq}, 16'd0);
        chk({tag, " xfer_ok"}, {15'd0, xfer_ok}, 16'd0);
        chk({tag, " fl_entry_addr"}, fl_entry_addr, 16'h0000);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] snap;

        do_reset();
        chk_defaults("R1 reset");

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata);
            @(negedge clk);
            rd(VECS[i].raddr, v);
            chk($sformatf("R%0d table[%0d]", VECS[i].req, i), v, VECS[i].exp);
        end

        do_reset();

        // R5: run clears halted one clock after run is stored
        wr(4'h0, 16'h0001);
        chk("R5 halted still set on store cycle", {15'd0, hc_halted}, 16'd1);
        @(negedge clk);
        chk("R5 halted cleared", {15'd0, hc_halted}, 16'd0);
        chk("R11 xfer_ok while running", {15'd0, xfer_ok}, 16'd1);

        // R6: advance, wrap, write beats tick
        repeat (3) tick();
        rd(4'h8, v); chk("R6 three ticks", v, 16'd3);
        wr(4'h8, 16'd1023);
        tick();
        rd(4'h8, v); chk("R6 wrap to zero", v, 16'd0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 16'd5; frame_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; frame_tick = 1'b0;
        rd(4'h8, v); chk("R6 write wins over tick", v, 16'd5);

        // R7: entry address composition
        wr(4'hA, 16'hA000);
        chk("R7 fl_entry_addr", fl_entry_addr, 16'hA014);

        // R11 / R12
        wr(4'h0, 16'h0009);
        chk("R11 suspend blocks", {15'd0, xfer_ok}, 16'd0);
        wr(4'h0, 16'h0081);
        chk("R12 max packet 64", {15'd0, max_pkt_64}, 16'd1);
        chk("R11 permit back", {15'd0, xfer_ok}, 16'd1);

        // R4: configure flag has no effect on outputs
        snap = {irq, hc_halted, xfer_ok, max_pkt_64, 2'b00, frame_idx};
        wr(4'h0, 16'h00C1);
        @(negedge clk);
        chk("R4 outputs unchanged", {irq, hc_halted, xfer_ok, max_pkt_64, 2'b00, frame_idx}, snap);
        chk("R4 entry addr unchanged", fl_entry_addr, 16'hA014);
        rd(4'h0, v); chk("R4 flag reads back", v, 16'h00C1);

        // R5: stop waits for the frame boundary
        wr(4'h0, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R5 no halt before tick", {15'd0, hc_halted}, 16'd0);
        tick();
        chk("R5 halt at tick", {15'd0, hc_halted}, 16'd1);
        rd(4'h8, v); chk("R6 no advance on stopping tick", v, 16'd5);

        // R8: halted write-one-to-clear, then tick sets it again
        wr(4'h2, 16'h0020);
        rd(4'h2, v); chk("R8 halted w1c", v, 16'h0000);
        tick();
        rd(4'h2, v); chk("R8 tick re-halts", v, 16'h0020);

        // R9 / R10: causes and enables
        evt(1'b1, 1'b0, 1'b0);
        rd(4'h2, v); chk("R9 done recorded", v, 16'h0021);
        chk("R10 done not enabled", {15'd0, irq}, 16'd0);
        wr(4'h4, 16'h0004);
        chk("R10 done enabled", {15'd0, irq}, 16'd1);
        wr(4'h2, 16'h0001);
        rd(4'h2, v); chk("R8 done cleared", v, 16'h0020);
        chk("R10 irq drops", {15'd0, irq}, 16'd0);
        evt(1'b0, 1'b0, 1'b1);
        rd(4'h2, v); chk("R9 short recorded", v, 16'h0021);
        chk("R10 short not enabled", {15'd0, irq}, 16'd0);
        wr(4'h4, 16'h0008);
        chk("R10 short enabled", {15'd0, irq}, 16'd1);
        wr(4'h2, 16'h0001);
        chk("R10 short cleared", {15'd0, irq}, 16'd0);
        evt(1'b0, 1'b1, 1'b0);
        rd(4'h2, v); chk("R9 err recorded", v, 16'h0022);
        chk("R10 err always raises", {15'd0, irq}, 16'd1);
        wr(4'h2, 16'h0000);
        rd(4'h2, v); chk("R8 zero write keeps", v, 16'h0022);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h2; reg_wdata = 16'h0002; evt_err = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_err = 1'b0;
        rd(4'h2, v); chk("R8 event beats clear", v, 16'h0022);
        wr(4'h2, 16'h0002);
        rd(4'h2, v); chk("R8 err cleared", v, 16'h0020);
        chk("R10 irq idle", {15'd0, irq}, 16'd0);

        // R3: controller reset
        wr(4'h4, 16'h000C);
        wr(4'h0, 16'h00C1);
        evt(1'b1, 1'b1, 1'b0);
        wr(4'h8, 16'd7);
        wr(4'h0, 16'h0002);
        rd(4'h0, v); chk("R3 reset bit visible one cycle", v, 16'h0002);
        @(negedge clk);
        chk_defaults("R3 after reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule